// File: doc/BRIEF.md
# Horizontal Polyphase Fine Scaler

This block resamples each line of a YUV 4:2:2 pixel stream along the horizontal axis by an arbitrary ratio. A single phase accumulator steps through the input line in units of 1/1024 pixel. On every output sample its integer carry says how many new input pixels must enter the tap window, and its top six fractional bits pick one of 64 fixed coefficient sets. The luma channel is filtered over ten taps. The chroma channel is filtered over four taps of Cb/Cr pairs. Chroma runs at exactly half the luma step and half the luma start offset, so the chroma position is derived from the same accumulator and is never programmed separately.

Input pixels arrive with a valid strobe and a line-start strobe. Ordinary pixels are taken only while the scaler asserts its ready output. The line-start pixel is always taken. Output samples leave with a single valid strobe, one per cycle at most. The step value is 1024 × (input pixels / output pixels), so 1024 means unity. The start offset is given in 1/32 pixel.

Top module: `hzPolyScaler`

## Requirements
- R1: Output sample n (counted from 0 after each line start) sits at input position x = phaseOffset·32 + n·lumaInc in 1/1024-pixel units. Its integer pixel is x>>10 and its filter phase is bits 9..4 of x.
- R2: The luma output at integer pixel i and phase p is Σ c(p,d)·Y[i+d] for d = −4..5. Indices below 0 use Y[0]. With s = (p·(64−p))>>6 and q = s>>2, the coefficients are: c(0)=64−p+s, c(1)=p+s, c(−1)=c(2)=−s−q, c(−2)=c(3)=q, and 0 elsewhere.
- R3: Input chroma carries Cb on even pixel indices and Cr on odd ones, and forms pairs j = (C[2j], C[2j+1]). Chroma is filtered at position x/2 with four taps d = −1..2 about integer pair x>>11, using phase bits 10..5 of x. With h = s>>1, the coefficients are c(0)=64−p+h, c(1)=p+h, c(−1)=c(2)=−h. Pair indices below 0 use pair 0. outC carries the filtered Cb on even output indices and the filtered Cr on odd ones.
- R4: Each filter sum is rounded by adding 32 and shifting right arithmetically by 6, then clamped to 0..255.
- R5: Output n is emitted once input pixel (x>>10)+5 of the line has been taken. outValid rises in the cycle after that condition is met. Outputs that would need pixels past the end of the line are not emitted.
- R6: A pixel with the line-start strobe is always taken and restarts the line. An output that was already due in that cycle is still emitted. No other output of the old line follows.
- R7: inReady is low only when no new pixel is needed before the next output, which happens only when lumaInc < 1024. inReady stays high throughout a line when lumaInc ≥ 1024.
- R8: Cycles with inValid low change no output value and no output order.
- R9: After reset, outValid is low and inReady is high.
- R10: At lumaInc = 1024 and phaseOffset = 0, the luma output reproduces the input line exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present |
| inSol | input | 1 | Input pixel is the first of a line |
| inY | input | 8 | Input luma |
| inC | input | 8 | Input chroma, Cb on even pixels and Cr on odd |
| inReady | output | 1 | Scaler takes an ordinary pixel this cycle |
| lumaInc | input | 13 | Step per output, 1024 = unity |
| phaseOffset | input | 8 | Start position of the line in 1/32 pixel |
| outValid | output | 1 | Output sample present |
| outY | output | 8 | Resampled luma |
| outC | output | 8 | Resampled chroma, Cb on even outputs and Cr on odd |

## Verification
A wrong fractional accumulator value shows at the ports as a wrong interpolated value on the very next output. A wrong pending-pixel count shows as an extra or missing output, or as a sample taken from a window shifted by whole pixels. These errors stay visible on every later output of the same line until the next line start. Misaligned chroma pairing shows up on alternate outputs through the Cb/Cr interleave. The bench compares every output of every line, and the output count per line, against a position model. It uses step, ramp and flat lines, which make clamping, phase errors and bubble sensitivity visible within a few samples.

// File: rtl/hzScalePkg.sv
package hzScalePkg;

  localparam int PHASE_W  = 6;
  localparam int COEF_ONE = 1 << PHASE_W;
  localparam int COEF_W   = 8;
  localparam int OFF_FRAC = 5;

  typedef struct packed {
    logic               start;
    logic               shift;
    logic               fire;
    logic               headOdd;
    logic [PHASE_W-1:0] lumaPhase;
    logic [PHASE_W-1:0] chromaPhase;
  } hzCtl_t;

  function automatic int sharpAmt(input logic [PHASE_W-1:0] p);
    int pi;
    pi = int'(p);
    return (pi * (COEF_ONE - pi)) >>> PHASE_W;
  endfunction

  function automatic logic signed [COEF_W-1:0] lumaCoef(input logic [PHASE_W-1:0] p, input int d);
    int pi, s, q, c;
    pi = int'(p);
    s  = sharpAmt(p);
    q  = s >>> 2;
    case (d)
      -2, 3:   c = q;
      -1, 2:   c = -s - q;
      0:       c = COEF_ONE - pi + s;
      1:       c = pi + s;
      default: c = 0;
    endcase
    return COEF_W'(c);
  endfunction

  function automatic logic signed [COEF_W-1:0] chromaCoef(input logic [PHASE_W-1:0] p, input int d);
    int pi, h, c;
    pi = int'(p);
    h  = sharpAmt(p) >>> 1;
    case (d)
      -1, 2:   c = -h;
      0:       c = COEF_ONE - pi + h;
      1:       c = pi + h;
      default: c = 0;
    endcase
    return COEF_W'(c);
  endfunction

endpackage

// File: rtl/hzScaleCtl.sv
module hzScaleCtl
  import hzScalePkg::*;
#(
  parameter int INC_W     = 13,
  parameter int FRAC_W    = 10,
  parameter int OFF_W     = 8,
  parameter int LUMA_TAPS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSol,
  input  logic [INC_W-1:0] lumaInc,
  input  logic [OFF_W-1:0] phaseOffset,
  output logic             inReady,
  output hzCtl_t           ctl
);

  localparam int OFF_INT_W = OFF_W - OFF_FRAC;
  localparam int LEAD      = LUMA_TAPS / 2;
  localparam int PEND_MAX  = (1 << OFF_INT_W) - 1 + LEAD;
  localparam int PEND_W    = $clog2(PEND_MAX + 1);
  localparam int STEP_W    = INC_W + 1;
  localparam int CARRY_W   = STEP_W - FRAC_W;

  logic              active;
  logic [FRAC_W-1:0] frac;
  logic [PEND_W-1:0] pend;
  logic              headOdd;

  logic [STEP_W-1:0]  stepSum;
  logic [CARRY_W-1:0] carry;
  logic               due, needPix, start, shift;

  always_comb begin
    stepSum = STEP_W'(frac) + STEP_W'(lumaInc);
    carry   = stepSum[STEP_W-1:FRAC_W];
    due     = active && (pend == '0);
    needPix = (pend != '0) || (carry != '0);
    inReady = !active || needPix;
    start   = inValid && inSol;
    shift   = inValid && !inSol && active && needPix;
  end

  always_comb begin
    ctl.start       = start;
    ctl.shift       = shift;
    ctl.fire        = due;
    ctl.headOdd     = headOdd;
    ctl.lumaPhase   = frac[FRAC_W-1 -: PHASE_W];
    ctl.chromaPhase = {~headOdd, frac[FRAC_W-1 -: PHASE_W-1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      frac    <= '0;
      pend    <= '0;
      headOdd <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      frac    <= {phaseOffset[OFF_FRAC-1:0], {(FRAC_W-OFF_FRAC){1'b0}}};
      pend    <= PEND_W'(phaseOffset[OFF_W-1:OFF_FRAC]) + PEND_W'(LEAD);
      headOdd <= 1'b0;
    end else begin
      if (due) begin
        frac <= stepSum[FRAC_W-1:0];
        pend <= PEND_W'(carry) - PEND_W'(shift);
      end else if (shift) begin
        pend <= pend - PEND_W'(1);
      end
      if (shift) headOdd <= ~headOdd;
    end
  end

  p_pend_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    pend <= PEND_W'(PEND_MAX));

  p_start_no_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSol) |=> !ctl.fire);

endmodule

// File: rtl/hzScaleDp.sv
module hzScaleDp
  import hzScalePkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int LUMA_TAPS   = 10,
  parameter int CHROMA_TAPS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inC,
  input  hzCtl_t           ctl,
  output logic             outValid,
  output logic [PIX_W-1:0] outY,
  output logic [PIX_W-1:0] outC
);

  localparam int SUM_W    = PIX_W + COEF_W + $clog2(LUMA_TAPS) + 1;
  localparam int LUMA_CTR = LUMA_TAPS / 2 - 1;
  localparam int CHR_CTR  = CHROMA_TAPS / 2 - 1;
  localparam logic signed [SUM_W-1:0] ROUND_S = SUM_W'(1 << (PHASE_W - 1));
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] lumaWin [LUMA_TAPS];
  logic [PIX_W-1:0] cbWin   [CHROMA_TAPS];
  logic [PIX_W-1:0] crWin   [CHROMA_TAPS];
  logic [PIX_W-1:0] cbHold;
  logic             firstPair;
  logic             outOdd;

  logic signed [SUM_W-1:0] lumaSum, cbSum, crSum;

  function automatic logic [PIX_W-1:0] satPix(input logic signed [SUM_W-1:0] a);
    logic signed [SUM_W-1:0] r;
    r = (a + ROUND_S) >>> PHASE_W;
    if (r < 0)            return '0;
    else if (r > PIX_MAX) return '1;
    else                  return r[PIX_W-1:0];
  endfunction

  always_comb begin
    lumaSum = '0;
    for (int k = 0; k < LUMA_TAPS; k++)
      lumaSum = lumaSum + SUM_W'(lumaCoef(ctl.lumaPhase, k - LUMA_CTR))
                        * $signed(SUM_W'(lumaWin[k]));
  end

  always_comb begin
    cbSum = '0;
    crSum = '0;
    for (int k = 0; k < CHROMA_TAPS; k++) begin
      cbSum = cbSum + SUM_W'(chromaCoef(ctl.chromaPhase, k - CHR_CTR))
                    * $signed(SUM_W'(cbWin[k]));
      crSum = crSum + SUM_W'(chromaCoef(ctl.chromaPhase, k - CHR_CTR))
                    * $signed(SUM_W'(crWin[k]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outY      <= '0;
      outC      <= '0;
      outOdd    <= 1'b0;
      cbHold    <= '0;
      firstPair <= 1'b0;
      for (int k = 0; k < LUMA_TAPS; k++) lumaWin[k] <= '0;
      for (int k = 0; k < CHROMA_TAPS; k++) begin
        cbWin[k] <= '0;
        crWin[k] <= '0;
      end
    end else begin
      outValid <= ctl.fire;
      if (ctl.fire) begin
        outY   <= satPix(lumaSum);
        outC   <= outOdd ? satPix(crSum) : satPix(cbSum);
        outOdd <= ~outOdd;
      end
      if (ctl.start) begin
        for (int k = 0; k < LUMA_TAPS; k++) lumaWin[k] <= inY;
        cbHold    <= inC;
        firstPair <= 1'b1;
        outOdd    <= 1'b0;
      end else if (ctl.shift) begin
        for (int k = 0; k < LUMA_TAPS - 1; k++) lumaWin[k] <= lumaWin[k+1];
        lumaWin[LUMA_TAPS-1] <= inY;
        if (ctl.headOdd) begin
          cbHold <= inC;
        end else if (firstPair) begin
          firstPair <= 1'b0;
          for (int k = 0; k < CHROMA_TAPS; k++) begin
            cbWin[k] <= cbHold;
            crWin[k] <= inC;
          end
        end else begin
          for (int k = 0; k < CHROMA_TAPS - 1; k++) begin
            cbWin[k] <= cbWin[k+1];
            crWin[k] <= crWin[k+1];
          end
          cbWin[CHROMA_TAPS-1] <= cbHold;
          crWin[CHROMA_TAPS-1] <= inC;
        end
      end
    end
  end

  p_shift_loads_newest_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> (lumaWin[LUMA_TAPS-1] == $past(inY)));

  p_fire_gives_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> outValid);

  p_no_fire_no_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> !outValid);

endmodule

// File: rtl/hzPolyScaler.sv
module hzPolyScaler
  import hzScalePkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int INC_W       = 13,
  parameter int FRAC_W      = 10,
  parameter int OFF_W       = 8,
  parameter int LUMA_TAPS   = 10,
  parameter int CHROMA_TAPS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSol,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inC,
  output logic             inReady,
  input  logic [INC_W-1:0] lumaInc,
  input  logic [OFF_W-1:0] phaseOffset,
  output logic             outValid,
  output logic [PIX_W-1:0] outY,
  output logic [PIX_W-1:0] outC
);

  hzCtl_t ctl;

  hzScaleCtl #(
    .INC_W(INC_W), .FRAC_W(FRAC_W), .OFF_W(OFF_W), .LUMA_TAPS(LUMA_TAPS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol),
    .lumaInc(lumaInc), .phaseOffset(phaseOffset),
    .inReady(inReady), .ctl(ctl)
  );

  hzScaleDp #(
    .PIX_W(PIX_W), .LUMA_TAPS(LUMA_TAPS), .CHROMA_TAPS(CHROMA_TAPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inY(inY), .inC(inC), .ctl(ctl),
    .outValid(outValid), .outY(outY), .outC(outC)
  );

endmodule

// File: tb/hzPolyScaler_tb.sv
`timescale 1ns/1ps
module hzPolyScaler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 9;
  // inc, offset, length, pattern, gaps, requirement id
  localparam int CASES [NCASE][6] = '{
    '{1024,   0, 24, 0, 0, 10},
    '{1024,  16, 24, 1, 0,  4},
    '{1024,  16, 24, 3, 0,  4},
    '{2048,   0, 40, 0, 0,  1},
    '{8191,   3, 64, 4, 0,  1},
    '{ 293,   0, 20, 4, 0,  2},
    '{ 700,  40, 30, 4, 1,  8},
    '{1536, 255, 40, 4, 0,  1},
    '{1024,   0, 16, 2, 1,  8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSol = 1'b0;
  logic [7:0] inY = '0, inC = '0;
  logic inReady;
  logic [12:0] lumaInc = 13'd1024;
  logic [7:0] phaseOffset = '0;
  logic outValid;
  logic [7:0] outY, outC;

  int nChecks = 0, nErr = 0, stallCnt = 0;
  int expY[$], expC[$], gotY[$], gotC[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hzPolyScaler u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol),
    .inY(inY), .inC(inC), .inReady(inReady),
    .lumaInc(lumaInc), .phaseOffset(phaseOffset),
    .outValid(outValid), .outY(outY), .outC(outC)
  );

  always @(negedge clk) if (rstN && outValid) begin
    gotY.push_back(int'(outY));
    gotC.push_back(int'(outC));
  end

  function automatic string reqName(int id);
    case (id)
      1: return "R1";  2: return "R2";  4: return "R4";
      8: return "R8";  10: return "R10"; default: return "R2";
    endcase
  endfunction

  function automatic int pixY(int pat, int i);
    case (pat)
      0: return (i * 7) & 255;
      1: return (i >= 12) ? 255 : 0;
      2: return 100;
      3: return (i >= 12) ? 0 : 255;
      default: return (i * 37 + 11 + i * i * 5) & 255;
    endcase
  endfunction

  function automatic int pixC(int pat, int i);
    case (pat)
      0: return 128 + ((i * 13) & 63);
      1: return (i >= 12) ? 240 : 16;
      2: return 60;
      3: return (i >= 12) ? 16 : 240;
      default: return (i * 53 + 90 + i * i * 3) & 255;
    endcase
  endfunction

  function automatic int sAmt(int p);
    return (p * (64 - p)) >>> 6;
  endfunction

  function automatic int cLuma(int p, int d);
    int s, q;
    s = sAmt(p); q = s >>> 2;
    if (d == -2 || d == 3) return q;
    if (d == -1 || d == 2) return -s - q;
    if (d == 0) return 64 - p + s;
    if (d == 1) return p + s;
    return 0;
  endfunction

  function automatic int cChroma(int p, int d);
    int h;
    h = sAmt(p) >>> 1;
    if (d == -1 || d == 2) return -h;
    if (d == 0) return 64 - p + h;
    return p + h;
  endfunction

  function automatic int clampPix(int acc);
    int r;
    r = (acc + 32) >>> 6;
    if (r < 0) return 0;
    if (r > 255) return 255;
    return r;
  endfunction

  task automatic model(int len, int inc, int off, int pat);
    for (int n = 0; n < 4096; n++) begin
      int x, il, p, acc, xc, ic, pc;
      x  = off * 32 + n * inc;
      il = x >>> 10;
      if (il + 5 > len - 1) break;
      p = (x >>> 4) & 63;
      acc = 0;
      for (int d = -4; d <= 5; d++) begin
        int idx;
        idx = (il + d < 0) ? 0 : il + d;
        acc += cLuma(p, d) * pixY(pat, idx);
      end
      expY.push_back(clampPix(acc));
      xc = x >>> 1;
      ic = xc >>> 10;
      pc = (xc >>> 4) & 63;
      acc = 0;
      for (int d = -1; d <= 2; d++) begin
        int j;
        j = (ic + d < 0) ? 0 : ic + d;
        acc += cChroma(pc, d) * pixC(pat, 2 * j + (n % 2));
      end
      expC.push_back(clampPix(acc));
    end
  endtask

  task automatic check(bit ok, string req, string what, int got, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic sendLine(int len, int pat, int gap);
    for (int i = 0; i < len; i++) begin
      if (gap != 0 && (i % 3) == 2) begin
        @(negedge clk); inValid = 1'b0; inSol = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inSol = (i == 0);
      inY = 8'(pixY(pat, i)); inC = 8'(pixC(pat, i));
      forever begin
        #1;
        if (inReady || inSol) break;
        stallCnt++;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inSol = 1'b0;
  endtask

  task automatic drainCompare(string reqY);
    int m;
    repeat (30) @(negedge clk);
    check(gotY.size() == expY.size(), "R5", "output count", gotY.size(), expY.size());
    m = (gotY.size() < expY.size()) ? gotY.size() : expY.size();
    for (int i = 0; i < m; i++) begin
      check(gotY[i] == expY[i], reqY, $sformatf("luma out %0d", i), gotY[i], expY[i]);
      check(gotC[i] == expC[i], "R3", $sformatf("chroma out %0d", i), gotC[i], expC[i]);
    end
    gotY.delete(); gotC.delete(); expY.delete(); expC.delete();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: idle state after reset
    check(outValid == 1'b0, "R9", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R9", "inReady after reset", int'(inReady), 1);

    for (int c = 0; c < NCASE; c++) begin
      lumaInc = 13'(CASES[c][0]);
      phaseOffset = 8'(CASES[c][1]);
      stallCnt = 0;
      model(CASES[c][2], CASES[c][0], CASES[c][1], CASES[c][3]);
      sendLine(CASES[c][2], CASES[c][3], CASES[c][4]);
      // R7: stalls only when zooming
      if (CASES[c][0] < 1024)
        check(stallCnt > 0, "R7", "stall cycles when zooming", stallCnt, 1);
      else
        check(stallCnt == 0, "R7", "stall cycles when not zooming", stallCnt, 0);
      drainCompare(reqName(CASES[c][5]));
    end

    // R6: line restart after a short line
    lumaInc = 13'd1024; phaseOffset = 8'd0;
    model(8, 1024, 0, 0);
    model(24, 1024, 0, 4);
    sendLine(8, 0, 0);
    sendLine(24, 4, 0);
    drainCompare("R6");

    // R9: reset in mid-line returns to idle
    lumaInc = 13'd1536; phaseOffset = 8'd20;
    sendLine(10, 4, 0);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R9", "outValid after mid-line reset", int'(outValid), 0);
    check(inReady == 1'b1, "R9", "inReady after mid-line reset", int'(inReady), 1);
    gotY.delete(); gotC.delete();

    // R10: unity line after reset is reproduced
    lumaInc = 13'd1024; phaseOffset = 8'd0;
    model(20, 1024, 0, 0);
    sendLine(20, 0, 0);
    drainCompare("R10");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule